// File: doc/BRIEF.md
# Forward Bit Scan Unit

This unit finds the lowest set bit of an operand. The scan starts at bit 0 and moves toward the most significant bit. It stops at bit 15 when the operand is 16 bits wide and at bit 31 when it is 32 bits wide. A caller presents the operand, a size select and the current value of the destination register. It then raises a valid strobe for one cycle. One clock later the unit returns the bit index in the destination output, a zero flag and a one-cycle done pulse.

When no bit in the scanned range is set, the zero flag goes high. The unit does not define a new index in that case, so the destination output carries forward the destination value that was supplied with the request. When no request is present, the outputs keep their last values.

Top module: `fwd_bitscan`

## Requirements
- R1: While synchronous active-low reset is applied, `done`, `zf_out` and `dest_out` are all 0.
- R2: `done` is high in the cycle after each cycle in which `in_valid` is high, and low in every other cycle. Back-to-back strobes give back-to-back pulses.
- R3: With `size_wide`=1, a valid request with a nonzero `operand[31:0]` drives `dest_out` to the index of the lowest set bit, zero-extended to 32 bits, one cycle later.
- R4: With `size_wide`=0, only `operand[15:0]` is scanned. Bits 31..16 have no effect on `dest_out` or `zf_out`.
- R5: A valid request whose scanned range holds at least one set bit drives `zf_out` to 0 one cycle later.
- R6: A valid request whose scanned range is all zero drives `zf_out` to 1 one cycle later. In that same cycle `dest_out` equals the `prev_dest` value presented with the request.
- R7: In a cycle after which `in_valid` was low, `dest_out` and `zf_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per scan |
| size_wide | input | 1 | 1 = 32-bit scan, 0 = 16-bit scan |
| operand | input | 32 | Value to scan |
| prev_dest | input | 32 | Current destination value, returned when the scan finds nothing |
| dest_out | output | 32 | Index of the lowest set bit, or the carried destination |
| zf_out | output | 1 | 1 when the scanned range was all zero |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench checks the extreme positions: bit 0, bit 31, and bit 15 in 16-bit mode. An off-by-one priority encoder, or one that scans in the wrong direction, would return the wrong index there.

It also sends 16-bit requests whose only set bits lie above bit 15. A unit that forgot to mask those bits would return an index of 16 or more with a cleared zero flag.

All-zero operands are sent with distinctive `prev_dest` patterns. A design that wrote index 0, or a stale value, instead of the carried destination would be caught. Idle gaps and back-to-back strobes expose outputs that change without a request, and done pulses that stretch or go missing.

// File: rtl/fbs_pkg.sv
// Package fbs_pkg
// Shared types for the forward bit scan unit.
// Assumes nothing beyond standard SystemVerilog.
package fbs_pkg;

    // Operand size select as seen on the size input
    typedef enum logic {
        SCAN_NARROW = 1'b0,
        SCAN_WIDE   = 1'b1
    } scan_size_e;

    // Registered result bundle
    typedef struct packed {
        logic        zero;
        logic        pulse;
    } scan_flags_t;

endpackage

// File: rtl/fbs_mask.sv
// Module fbs_mask
// Clears operand bits above the narrow width when a narrow scan is selected.
// Assumes NARROW_W <= DATA_W. When the two widths are equal, no masking is built.
module fbs_mask #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              size_wide,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] scanned
);
    import fbs_pkg::*;

    localparam int UPPER_W = DATA_W - NARROW_W;

    generate
        if (UPPER_W > 0) begin : g_mask
            // Zero the upper field unless the wide size is selected
            always_comb begin
                if (scan_size_e'(size_wide) == SCAN_WIDE) begin
                    scanned = operand;
                end else begin
                    scanned = {{UPPER_W{1'b0}}, operand[NARROW_W-1:0]};
                end
            end
        end else begin : g_pass
            // Both widths equal: nothing to mask
            assign scanned = operand;
        end
    endgenerate

endmodule

// File: rtl/fbs_lowest.sv
// Module fbs_lowest
// Finds the index of the least significant set bit of a vector.
// Isolates that bit as a one-hot word, then encodes it.
// Assumes the caller masks out any bits that must not take part in the scan.
module fbs_lowest #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] vec,
    output logic [IDX_W-1:0]  idx,
    output logic              none_set
);

    logic [DATA_W-1:0] twos;
    logic [DATA_W-1:0] onehot;
    logic [DATA_W-1:0] below;

    // Two's complement so that vec & -vec leaves only the lowest one
    assign twos     = (~vec) + {{(DATA_W-1){1'b0}}, 1'b1};
    assign onehot   = vec & twos;
    assign none_set = ~|vec;

    // Mask of positions strictly below the encoded index, used by the checks
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_below
            assign below[g] = (IDX_W'(g) < idx);
        end
    endgenerate

    // Encode the one-hot word into a binary index
    always_comb begin
        idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (onehot[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    // Isolation must leave at most one bit, and exactly one when the input is nonzero
    always_comb begin
        AST_ONE_WINNER: assert ($onehot0(onehot) && (none_set || $countones(onehot) == 1)); // R3
        AST_INDEX_IS_SET: assert (none_set || vec[idx]); // R3
        AST_NOTHING_BELOW: assert (none_set || ((vec & below) == '0)); // R3
    end

endmodule

// File: rtl/fbs_outreg.sv
// Module fbs_outreg
// Result register: captures the index or carries the destination, and makes the done pulse.
// Assumes a synchronous active-low reset and one request per strobe cycle.
module fbs_outreg #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              found_none,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] prev_dest,
    output logic [DATA_W-1:0] dest_out,
    output logic              zf_out,
    output logic              done
);
    import fbs_pkg::*;

    scan_flags_t flags_q;

    // Destination update: new index on a hit, carried value on a miss, hold when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_out <= '0;
        end else if (in_valid) begin
            if (found_none) begin
                dest_out <= prev_dest;
            end else begin
                dest_out <= {{(DATA_W-IDX_W){1'b0}}, idx};
            end
        end
    end

    // Flag update: zero flag follows each request, pulse marks it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q.pulse <= in_valid;
            if (in_valid) begin
                flags_q.zero <= found_none;
            end
        end
    end

    assign zf_out = flags_q.zero;
    assign done   = flags_q.pulse;

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dest_out) && $stable(zf_out))); // R7

endmodule

// File: rtl/fwd_bitscan.sv
// Module fwd_bitscan
// Forward bit scan: reports the lowest set bit of a 16- or 32-bit operand one clock after a strobe.
// Assumes prev_dest holds the caller's current destination value, which is returned on an empty scan.
module fwd_bitscan #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              size_wide,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] prev_dest,
    output logic [DATA_W-1:0] dest_out,
    output logic              zf_out,
    output logic              done
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] scanned;
    logic [IDX_W-1:0]  low_idx;
    logic              none_set;

    fbs_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_mask (
        .size_wide (size_wide),
        .operand   (operand),
        .scanned   (scanned)
    );

    fbs_lowest #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lowest (
        .vec      (scanned),
        .idx      (low_idx),
        .none_set (none_set)
    );

    fbs_outreg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .found_none (none_set),
        .idx        (low_idx),
        .prev_dest  (prev_dest),
        .dest_out   (dest_out),
        .zf_out     (zf_out),
        .done       (done)
    );

    // Port-level view of whether the selected range holds any set bit, for the checks below
    logic narrow_any;
    logic wide_any;
    assign narrow_any = |operand[NARROW_W-1:0];
    assign wide_any   = |operand;

    AST_HIT_CLEARS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (size_wide ? wide_any : narrow_any)) |=> !zf_out); // R5
    AST_MISS_SETS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(size_wide ? wide_any : narrow_any)) |=> (zf_out && dest_out == $past(prev_dest))); // R6
    AST_NARROW_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size_wide && narrow_any) |=> (dest_out < DATA_W'(NARROW_W))); // R4

endmodule

// File: tb/fwd_bitscan_bench.sv
module fwd_bitscan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        size_wide = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] prev_dest = '0;
    logic [31:0] dest_out;
    logic        zf_out;
    logic        done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    // Reference state
    logic [31:0] exp_dest = '0;
    logic        exp_zf = 1'b0;
    logic        exp_done = 1'b0;
    string       tag_dest = "R1";
    string       tag_zf = "R1";
    string       tag_done = "R1";

    always #10 clk = ~clk;

    fwd_bitscan u_fwd_bitscan (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .size_wide (size_wide),
        .operand   (operand),
        .prev_dest (prev_dest),
        .dest_out  (dest_out),
        .zf_out    (zf_out),
        .done      (done)
    );

    function automatic int ref_scan(logic [31:0] v, logic wide);
        int top;
        top = wide ? 32 : 16;
        for (int i = 0; i < top; i++) begin
            if (v[i]) return i;
        end
        return -1;
    endfunction

    // Behavioural reference, advanced at every rising edge
    always @(posedge clk) begin
        int hit;
        started <= 1'b1;
        if (!rst_n) begin
            exp_dest <= '0; exp_zf <= 1'b0; exp_done <= 1'b0;
            tag_dest <= "R1"; tag_zf <= "R1"; tag_done <= "R1";
        end else begin
            exp_done <= in_valid;
            tag_done <= "R2";
            if (in_valid) begin
                hit = ref_scan(operand, size_wide);
                if (hit < 0) begin
                    exp_dest <= prev_dest; exp_zf <= 1'b1;
                    tag_dest <= "R6"; tag_zf <= "R6";
                end else begin
                    exp_dest <= 32'(hit); exp_zf <= 1'b0;
                    tag_dest <= size_wide ? "R3" : "R4"; tag_zf <= "R5";
                end
            end else begin
                tag_dest <= "R7"; tag_zf <= "R7";
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            tests++;
            if (done !== exp_done) begin
                fails++;
                $display("FAIL %s done: actual %0b expected %0b", tag_done, done, exp_done);
            end
            tests++;
            if (zf_out !== exp_zf) begin
                fails++;
                $display("FAIL %s zf_out: actual %0b expected %0b", tag_zf, zf_out, exp_zf);
            end
            tests++;
            if (dest_out !== exp_dest) begin
                fails++;
                $display("FAIL %s dest_out: actual %h expected %h", tag_dest, dest_out, exp_dest);
            end
        end
    end

    task automatic req(input logic wide, input logic [31:0] op, input logic [31:0] pd);
        @(negedge clk);
        in_valid = 1'b1; size_wide = wide; operand = op; prev_dest = pd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand = 32'hFFFF_FFFF; prev_dest = 32'h1234_5678; size_wide = ~size_wide;
        end
    endtask

    initial begin
        idle(3);                                  // R1 reset state
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        req(1'b1, 32'h0000_0001, 32'hAAAA_AAAA);  // R3 bit 0
        req(1'b1, 32'h8000_0000, 32'hAAAA_AAAA);  // R3 bit 31, back-to-back R2
        req(1'b1, 32'h0010_0100, 32'h0);          // R3 two bits, lower wins
        idle(2);                                  // R7 hold
        req(1'b0, 32'h0000_8000, 32'h0);          // R4 bit 15
        req(1'b0, 32'hFFFF_0000, 32'hDEAD_BEEF);  // R4 R6 upper bits ignored
        idle(1);
        req(1'b1, 32'hFFFF_0000, 32'hDEAD_BEEF);  // R3 same operand wide
        req(1'b1, 32'h0000_0000, 32'h0BAD_F00D);  // R6 wide zero
        idle(3);                                  // R7
        req(1'b0, 32'h1234_0008, 32'h5);          // R4 R5
        req(1'b0, 32'h0000_0000, 32'h0000_001F);  // R6 narrow zero
        for (int k = 0; k < 400; k++) begin
            logic [31:0] v;
            v = $urandom();
            if (k % 5 == 0) v = v & ($urandom() << 20);
            if (k % 7 == 0) v = 32'h0;
            if ($urandom() % 4 == 0) idle(1 + $urandom() % 3);
            req(1'($urandom()), v, $urandom());
        end
        idle(3);
        @(negedge clk); rst_n = 1'b0;
        idle(2);                                  // R1 reset again
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule